// File: doc/BRIEF.md
# Nearest Palette Colour Matcher

This block holds a 256-entry table of RGB colours and, for each query colour, returns the table index whose colour lies nearest to it together with the distance found. The table is loaded one entry per cycle through a write port. A query is offered with a valid/ready handshake. It carries the colour and its own choice of metric: the plain sum of absolute channel differences, or a sum of squared channel differences with a separate 4-bit weight for red, green and blue.

The block walks the whole table at one entry per cycle and keeps a running best. Squares come from a 256-entry lookup table indexed by the absolute channel difference, so no multiplier is used. Each square is scaled by its weight through a shift-add. The scan always covers every entry, so every query takes the same fixed number of cycles. While a search is running, the block refuses both new queries and palette writes by holding its ready outputs low.

Top module: `paletteMatcher`

## Requirements
- R1: When palWe and palReady are both high at a clock edge, entry palAddr takes palData, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0; a query accepted at the same edge already sees the new value.
- R2: A query is accepted at an edge where qValid and qReady are high; resValid is a one-cycle pulse exactly 258 clock edges after that edge (256 scan cycles plus 2 pipeline cycles).
- R3: qReady and palReady stay low from the accepting edge until the cycle in which resValid is high, and are high in that cycle.
- R4: With qMetric = 0, the distance is |dR| + |dG| + |dB| and never exceeds 765.
- R5: With qMetric = 1, the distance is wR*dR² + wG*dG² + wB*dB², using the 4-bit unsigned weights qWgtR, qWgtG and qWgtB.
- R6: When several entries share the smallest distance, resIndex is the lowest of their indices.
- R7: An exact match gives resDist = 0 with no change in latency.
- R8: A palette write offered while palReady is low has no effect on the table.
- R9: The query colour, metric and weights are captured at acceptance; later changes on those inputs do not alter the running search.
- R10: After reset, qReady and palReady are high, resValid is low and every palette entry is black (all zero).
- R11: The distance output is 22 bits wide and holds the largest possible weighted distance, 2926125, without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| palWe | input | 1 | Palette write request |
| palAddr | input | 8 | Palette entry to write |
| palData | input | 24 | Colour to write, R/G/B from high to low byte |
| palReady | output | 1 | Palette writes are accepted |
| qValid | input | 1 | Query offered |
| qReady | output | 1 | Query can be accepted |
| qColor | input | 24 | Query colour, R/G/B from high to low byte |
| qMetric | input | 1 | 0 = absolute-difference sum, 1 = weighted squared sum |
| qWgtR | input | 4 | Red weight for the squared metric |
| qWgtG | input | 4 | Green weight for the squared metric |
| qWgtB | input | 4 | Blue weight for the squared metric |
| resValid | output | 1 | Result pulse |
| resIndex | output | 8 | Index of the nearest entry |
| resDist | output | 22 | Distance of the nearest entry |

## Verification
Some rules are checked by the assertions on every cycle: the fixed 258-edge gap between acceptance and result, the single-cycle result pulse, both ready outputs staying low while a search runs and rising with the result, and the bounds on the reported distance for each metric. Other behaviour shows only in the bench's scenarios, where the winning index and distance are compared with a behavioural model: the metric arithmetic itself, the lowest-index choice on ties, a write rejected during a search and input changes made after acceptance.

// File: rtl/pmPkg.sv
package pmPkg;

  // Strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic loadQuery;   // capture query colour, metric, weights
    logic issue;       // scanIdx holds an entry to evaluate
    logic lastIssue;   // this issue is the final table entry
  } pmStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2
  } pmState_t;

  typedef enum logic {
    METRIC_ABS = 1'b0,
    METRIC_WSQ = 1'b1
  } pmMetric_t;

endpackage

// File: rtl/pmSquareLut.sv
module pmSquareLut #(
  parameter int CH_W = 8,
  localparam int SQ_W = 2 * CH_W,
  localparam int DEPTH = 2 ** CH_W
) (
  input  logic [CH_W-1:0] diff,
  output logic [SQ_W-1:0] square
);

  logic [SQ_W-1:0] table_q [DEPTH];

  // Table of squares built at elaboration; read with a plain index
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign table_q[i] = SQ_W'(i * i);
  end

  assign square = table_q[diff];

endmodule

// File: rtl/pmControl.sv
module pmControl import pmPkg::*; #(
  parameter int ENTRIES  = 256,
  parameter int PIPE_LAT = 2,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int DRAIN_W = $clog2(PIPE_LAT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             qValid,
  output logic             idle,
  output pmStrobe_t        strobe,
  output logic [IDX_W-1:0] scanIdx
);

  localparam logic [IDX_W-1:0]   LAST_IDX  = IDX_W'(ENTRIES - 1);
  localparam logic [DRAIN_W-1:0] LAST_DRAIN = DRAIN_W'(PIPE_LAT - 1);

  pmState_t           state;
  logic [DRAIN_W-1:0] drainCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      scanIdx  <= '0;
      drainCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (qValid) begin
            state   <= ST_SCAN;
            scanIdx <= '0;
          end
        end
        ST_SCAN: begin
          scanIdx <= scanIdx + 1'b1;
          if (scanIdx == LAST_IDX) begin
            state    <= ST_DRAIN;
            drainCnt <= '0;
          end
        end
        ST_DRAIN: begin
          if (drainCnt == LAST_DRAIN) begin
            state <= ST_IDLE;
          end else begin
            drainCnt <= drainCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idle = (state == ST_IDLE);

  always_comb begin
    strobe.loadQuery = idle && qValid;
    strobe.issue     = (state == ST_SCAN);
    strobe.lastIssue = (state == ST_SCAN) && (scanIdx == LAST_IDX);
  end

endmodule

// File: rtl/pmDatapath.sv
module pmDatapath import pmPkg::*; #(
  parameter int CH_W    = 8,
  parameter int ENTRIES = 256,
  parameter int WGT_W   = 4,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int COL_W  = 3 * CH_W,
  localparam int SQ_W   = 2 * CH_W,
  localparam int DIST_W = 2 * CH_W + WGT_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  pmStrobe_t          strobe,
  input  logic [IDX_W-1:0]   scanIdx,
  input  logic               palWrite,
  input  logic [IDX_W-1:0]   palAddr,
  input  logic [COL_W-1:0]   palData,
  input  logic [COL_W-1:0]   qColor,
  input  logic               qMetric,
  input  logic [3*WGT_W-1:0] qWeights,
  output logic               resValid,
  output logic [IDX_W-1:0]   resIndex,
  output logic [DIST_W-1:0]  resDist
);

  // ---------------- palette table ----------------
  logic [COL_W-1:0] palTable [ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) palTable[i] <= '0;
    end else if (palWrite) begin
      palTable[palAddr] <= palData;
    end
  end

  // ---------------- captured query ----------------
  logic [COL_W-1:0] qColorLat;
  pmMetric_t        metricLat;
  logic [WGT_W-1:0] wgtLat [3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qColorLat <= '0;
      metricLat <= METRIC_ABS;
      for (int c = 0; c < 3; c++) wgtLat[c] <= '0;
    end else if (strobe.loadQuery) begin
      qColorLat <= qColor;
      metricLat <= pmMetric_t'(qMetric);
      for (int c = 0; c < 3; c++) wgtLat[c] <= qWeights[c*WGT_W +: WGT_W];
    end
  end

  // ---------------- stage 1: table read and channel differences ----------------
  logic [COL_W-1:0] entryRd;
  logic [CH_W-1:0]  diffNext [3];
  logic [CH_W-1:0]  s1Diff   [3];
  logic             s1Valid;
  logic             s1Last;
  logic [IDX_W-1:0] s1Idx;

  assign entryRd = palTable[scanIdx];

  for (genvar c = 0; c < 3; c++) begin : g_diff
    logic [CH_W-1:0] chEntry;
    logic [CH_W-1:0] chQuery;
    assign chEntry     = entryRd[c*CH_W +: CH_W];
    assign chQuery     = qColorLat[c*CH_W +: CH_W];
    assign diffNext[c] = (chEntry >= chQuery) ? (chEntry - chQuery) : (chQuery - chEntry);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Last  <= 1'b0;
      s1Idx   <= '0;
      for (int c = 0; c < 3; c++) s1Diff[c] <= '0;
    end else begin
      s1Valid <= strobe.issue;
      s1Last  <= strobe.lastIssue;
      if (strobe.issue) begin
        s1Idx <= scanIdx;
        for (int c = 0; c < 3; c++) s1Diff[c] <= diffNext[c];
      end
    end
  end

  // ---------------- stage 2: distance and running best ----------------
  logic [DIST_W-1:0] wsqTerm [3];

  for (genvar c = 0; c < 3; c++) begin : g_wsq
    logic [SQ_W-1:0] sqVal;

    pmSquareLut #(.CH_W(CH_W)) sq_i (
      .diff  (s1Diff[c]),
      .square(sqVal)
    );

    // Weight applied by shift-add over the weight bits
    always_comb begin
      wsqTerm[c] = '0;
      for (int b = 0; b < WGT_W; b++) begin
        if (wgtLat[c][b]) wsqTerm[c] = wsqTerm[c] + (DIST_W'(sqVal) << b);
      end
    end
  end

  logic [DIST_W-1:0] absSum;
  logic [DIST_W-1:0] wsqSum;
  logic [DIST_W-1:0] distNow;

  assign absSum  = DIST_W'(s1Diff[0]) + DIST_W'(s1Diff[1]) + DIST_W'(s1Diff[2]);
  assign wsqSum  = wsqTerm[0] + wsqTerm[1] + wsqTerm[2];
  assign distNow = (metricLat == METRIC_WSQ) ? wsqSum : absSum;

  logic [DIST_W-1:0] bestDist;
  logic [IDX_W-1:0]  bestIdx;
  logic              s2Done;
  logic              takeNew;

  // Strict less-than keeps the earlier (lower) index on ties
  assign takeNew = s1Valid && ((s1Idx == '0) || (distNow < bestDist));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestDist <= '0;
      bestIdx  <= '0;
      s2Done   <= 1'b0;
    end else begin
      s2Done <= s1Valid && s1Last;
      if (takeNew) begin
        bestDist <= distNow;
        bestIdx  <= s1Idx;
      end
    end
  end

  // ---------------- result register ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resIndex <= '0;
      resDist  <= '0;
    end else begin
      resValid <= s2Done;
      if (s2Done) begin
        resIndex <= bestIdx;
        resDist  <= bestDist;
      end
    end
  end

endmodule

// File: rtl/paletteMatcher.sv
module paletteMatcher import pmPkg::*; #(
  parameter int CH_W    = 8,
  parameter int ENTRIES = 256,
  parameter int WGT_W   = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            palWe,
  input  logic [$clog2(ENTRIES)-1:0]      palAddr,
  input  logic [3*CH_W-1:0]               palData,
  output logic                            palReady,
  input  logic                            qValid,
  output logic                            qReady,
  input  logic [3*CH_W-1:0]               qColor,
  input  logic                            qMetric,
  input  logic [WGT_W-1:0]                qWgtR,
  input  logic [WGT_W-1:0]                qWgtG,
  input  logic [WGT_W-1:0]                qWgtB,
  output logic                            resValid,
  output logic [$clog2(ENTRIES)-1:0]      resIndex,
  output logic [2*CH_W+WGT_W+1:0]         resDist
);

  localparam int IDX_W    = $clog2(ENTRIES);
  localparam int PIPE_LAT = 2;

  pmStrobe_t        strobe;
  logic [IDX_W-1:0] scanIdx;
  logic             idle;

  pmControl #(
    .ENTRIES (ENTRIES),
    .PIPE_LAT(PIPE_LAT)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .qValid (qValid),
    .idle   (idle),
    .strobe (strobe),
    .scanIdx(scanIdx)
  );

  pmDatapath #(
    .CH_W   (CH_W),
    .ENTRIES(ENTRIES),
    .WGT_W  (WGT_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .scanIdx (scanIdx),
    .palWrite(palWe && idle),
    .palAddr (palAddr),
    .palData (palData),
    .qColor  (qColor),
    .qMetric (qMetric),
    .qWeights({qWgtR, qWgtG, qWgtB}),
    .resValid(resValid),
    .resIndex(resIndex),
    .resDist (resDist)
  );

  assign qReady   = idle;
  assign palReady = idle;

endmodule

// File: rtl/pmChecker.sv
module pmChecker #(
  parameter int CH_W    = 8,
  parameter int ENTRIES = 256,
  parameter int WGT_W   = 4,
  localparam int DIST_W = 2 * CH_W + WGT_W + 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              qValid,
  input logic              qReady,
  input logic              palReady,
  input logic              qMetric,
  input logic              resValid,
  input logic [DIST_W-1:0] resDist
);

  localparam int          LATENCY  = ENTRIES + 2;
  localparam int          CH_MAX   = 2 ** CH_W - 1;
  localparam longint      ABS_MAX  = 3 * CH_MAX;
  localparam longint      WSQ_MAX  = longint'(3) * (2 ** WGT_W - 1) * CH_MAX * CH_MAX;

  logic        pend;
  logic [15:0] sinceAcc;
  logic        metricLat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend      <= 1'b0;
      sinceAcc  <= '0;
      metricLat <= 1'b0;
    end else if (qValid && qReady) begin
      pend      <= 1'b1;
      sinceAcc  <= '0;
      metricLat <= qMetric;
    end else if (resValid) begin
      pend <= 1'b0;
    end else if (pend) begin
      sinceAcc <= sinceAcc + 1'b1;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (pend && (32'(sinceAcc) == LATENCY)));

  assert_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  assert_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pend && !resValid) |-> (!qReady && !palReady));

  assert_ready_back_R3: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (qReady && palReady));

  assert_abs_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !metricLat) |-> (64'(resDist) <= ABS_MAX));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (64'(resDist) <= WSQ_MAX));

endmodule

bind paletteMatcher pmChecker #(
  .CH_W   (CH_W),
  .ENTRIES(ENTRIES),
  .WGT_W  (WGT_W)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .qValid  (qValid),
  .qReady  (qReady),
  .palReady(palReady),
  .qMetric (qMetric),
  .resValid(resValid),
  .resDist (resDist)
);

// File: tb/paletteMatcher_tb_top.sv
`timescale 1ns/1ps
module paletteMatcher_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        palWe = 1'b0;
  logic [7:0]  palAddr = '0;
  logic [23:0] palData = '0;
  logic        palReady;
  logic        qValid = 1'b0;
  logic        qReady;
  logic [23:0] qColor = '0;
  logic        qMetric = 1'b0;
  logic [3:0]  qWgtR = '0;
  logic [3:0]  qWgtG = '0;
  logic [3:0]  qWgtB = '0;
  logic        resValid;
  logic [7:0]  resIndex;
  logic [21:0] resDist;

  always #5 clk = ~clk;

  paletteMatcher dut_i (
    .clk(clk), .rstN(rstN),
    .palWe(palWe), .palAddr(palAddr), .palData(palData), .palReady(palReady),
    .qValid(qValid), .qReady(qReady), .qColor(qColor), .qMetric(qMetric),
    .qWgtR(qWgtR), .qWgtG(qWgtG), .qWgtB(qWgtB),
    .resValid(resValid), .resIndex(resIndex), .resDist(resDist)
  );

  int    nCompared = 0;
  int    nFailed   = 0;
  int    cycles    = 0;
  string curReq    = "R10";
  bit    running   = 1'b0;

  task automatic checkVal(input string req, input string what,
                          input longint act, input longint exp);
    nCompared++;
    if (act !== exp) begin
      nFailed++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mPal [256];
  bit mPend = 1'b0;
  int mCnt = 0;
  bit mRes = 1'b0;
  int mResIdx = 0;
  int mResDist = 0;
  int mNextIdx = 0;
  int mNextDist = 0;

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic modelSearch(input int col, input bit met, input int wr, input int wg,
                             input int wb, output int bi, output int bd);
    bi = 0; bd = 0;
    for (int e = 0; e < 256; e++) begin
      int dr, dg, db, d;
      dr = absd((mPal[e] >> 16) & 255, (col >> 16) & 255);
      dg = absd((mPal[e] >> 8) & 255, (col >> 8) & 255);
      db = absd(mPal[e] & 255, col & 255);
      d  = met ? (wr*dr*dr + wg*dg*dg + wb*db*db) : (dr + dg + db);
      if (e == 0 || d < bd) begin bi = e; bd = d; end
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mPend = 1'b0; mCnt = 0; mRes = 1'b0;
      for (int i = 0; i < 256; i++) mPal[i] = 0;
    end else begin
      bit readyNow;
      readyNow = !mPend;
      mRes = 1'b0;
      if (mPend) begin
        mCnt++;
        if (mCnt == 258) begin
          mRes = 1'b1; mPend = 1'b0;
          mResIdx = mNextIdx; mResDist = mNextDist;
        end
      end
      if (readyNow && palWe) mPal[palAddr] = int'(palData);
      if (readyNow && qValid) begin
        modelSearch(int'(qColor), qMetric, int'(qWgtR), int'(qWgtG), int'(qWgtB),
                    mNextIdx, mNextDist);
        mPend = 1'b1; mCnt = 0;
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      checkVal("R3", "qReady", qReady, !mPend);
      checkVal("R3", "palReady", palReady, !mPend);
      checkVal("R2", "resValid", resValid, mRes);
      if (mRes) begin
        checkVal(curReq, "resIndex", resIndex, mResIdx);
        checkVal(curReq, "resDist", resDist, mResDist);
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFailed++;
      $display("FAIL R2 watchdog: actual %0d cycles expected below 100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nFailed);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic writeEntry(input int addr, input int data);
    palWe   = 1'b1;
    palAddr = 8'(addr);
    palData = 24'(data);
    @(negedge clk);
    palWe   = 1'b0;
  endtask

  task automatic launch(input int col, input bit met, input int wr, input int wg,
                        input int wb, input string req);
    curReq  = req;
    qColor  = 24'(col);
    qMetric = met;
    qWgtR = 4'(wr); qWgtG = 4'(wg); qWgtB = 4'(wb);
    qValid  = 1'b1;
    @(negedge clk);
    qValid  = 1'b0;
  endtask

  task automatic runQuery(input int col, input bit met, input int wr, input int wg,
                          input int wb, input string req);
    launch(col, met, wr, wg, wb, req);
    repeat (262) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state at the ports
    checkVal("R10", "qReady after reset", qReady, 1);
    checkVal("R10", "palReady after reset", palReady, 1);
    checkVal("R10", "resValid after reset", resValid, 0);
    running = 1'b1;

    // R10: cleared table, nearest is entry 0 at black
    runQuery(32'h0A141E, 1'b0, 0, 0, 0, "R10");

    // R1: load a table pattern
    for (int i = 0; i < 256; i++)
      writeEntry(i, (i << 16) | ((255 - i) << 8) | ((i * 7) & 255));
    @(negedge clk);

    // R1: query equal to a loaded entry must find it
    runQuery((77 << 16) | (178 << 8) | ((77 * 7) & 255), 1'b0, 0, 0, 0, "R1");
    // R4: absolute-difference metric
    runQuery(32'h643209, 1'b0, 0, 0, 0, "R4");
    // R5: weighted squared metric
    runQuery(32'h25B4FA, 1'b1, 1, 2, 3, "R5");
    runQuery(32'hF01080, 1'b1, 15, 0, 7, "R5");

    // R6 / R7: two identical entries equal to the query
    writeEntry(5, 32'hC8014D);
    writeEntry(6, 32'hC8014D);
    @(negedge clk);
    runQuery(32'hC8014D, 1'b0, 0, 0, 0, "R6");
    runQuery(32'hC8014D, 1'b1, 3, 3, 3, "R7");

    // R8: writes offered during a search are refused
    launch(32'h102030, 1'b0, 0, 0, 0, "R8");
    repeat (10) @(negedge clk);
    writeEntry(0, 32'hABCDEF);
    writeEntry(255, 32'hABCDEF);
    repeat (255) @(negedge clk);
    runQuery(32'hABCDEF, 1'b0, 0, 0, 0, "R8");

    // R9: inputs changed after acceptance do not matter
    launch(32'h3C3C3C, 1'b0, 0, 0, 0, "R9");
    qMetric = 1'b1; qWgtR = 4'd15; qWgtG = 4'd1; qWgtB = 4'd9; qColor = 24'hFFFFFF;
    repeat (40) @(negedge clk);
    qValid = 1'b1;          // offered while busy: must be ignored
    @(negedge clk);
    qValid = 1'b0;
    repeat (225) @(negedge clk);

    // R11: largest weighted distance, black table against white
    for (int i = 0; i < 256; i++) writeEntry(i, 0);
    @(negedge clk);
    runQuery(32'hFFFFFF, 1'b1, 15, 15, 15, "R11");
    checkVal("R11", "max distance", resDist, 2926125);
    checkVal("R6", "tie over whole table picks 0", resIndex, 0);

    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nFailed);
    $finish;
  end

endmodule